// File: doc/BRIEF.md
# 8-bit ALU with registered flag byte

This block is the arithmetic and logic stage of a small accumulator machine. The accumulator, a second operand and a 4-bit operation code go in. A combinational core returns the 8-bit result, a write-back enable for the accumulator, and the flag byte that the operation would produce. Each operation has its own rule for each flag: it sets it, clears it, computes it or keeps it.

The flags are zero, subtract, half-carry (a carry or borrow at the nibble boundary) and carry. They sit in a flag register inside the block, and that register is also the flag input of the core. The register loads the core's flag byte only on a cycle where the valid strobe is high. Operations that chain on the carry flag therefore see the outcome of the last valid operation.

Top module: `alu_flag_unit`

## Requirements
- R1: The flag byte has zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3..0 always read 0. After reset, flags_o is 0x00.
- R2: Op 0 (add): result = (A+B) mod 256. Z = (result==0), N = 0. H = ((A&0xF)+(B&0xF) > 0xF). C = carry out of bit 7.
- R3: Op 1 (add with carry): like R2, with Cin = the current carry flag. H = ((A&0xF)+(B&0xF)+Cin > 0xF) and C = (A+B+Cin > 0xFF).
- R4: Op 2 (subtract): result = (A-B) mod 256. Z from the result, N = 1. H = ((A&0xF) < (B&0xF)). C = (A < B).
- R5: Op 3 (subtract with carry): result = (A-B-Cin) mod 256 with Cin = the current carry. N = 1, H = ((A&0xF) < (B&0xF)+Cin) and C = (A < B+Cin), both compared without truncation.
- R6: Op 4 (AND): result = A&B. Z from the result, N = 0, H = 1, C = 0.
- R7: Op 5 (XOR) and op 6 (OR): result = A^B or A|B. Z from the result, and N, H and C cleared.
- R8: Op 7 (compare): flags as in R4, wb_o = 0 and result_o = A.
- R9: Op 8 (complement): result = ~A, N = 1, H = 1, and Z and C kept.
- R10: Op 9 (set carry) forces C to 1. Op 10 (complement carry) inverts C. Both clear N and H, keep Z, drive wb_o = 0 and give result_o = A.
- R11: flags_o takes next_flags_o on a rising clock edge only while valid_i is high, and otherwise holds its value.
- R12: Codes 11..15 give wb_o = 0, result_o = A and next_flags_o = flags_o.
- R13: wb_o is 1 exactly for ops 0..6 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Flag register load strobe |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| result_o | output | 8 | Result byte |
| wb_o | output | 1 | Accumulator write-back enable |
| next_flags_o | output | 8 | Flag byte the current operation produces |
| flags_o | output | 8 | Registered flag byte |

## Verification
The hardest case to reach is a subtract with carry where B is 0xFF and the stored carry is 1. Here B+Cin reaches 256, so a truncating comparison would get both the carry and the half-carry wrong. Reaching it from the ports takes a sequence: a valid set-carry or carry-producing operation first, then the subtract with carry. Directed sequences build that case and the matching add case (0xFF + 0x00 + 1). Seeded random sequences, with valid dropped about a quarter of the time, cover carry chains through the register.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int F_Z = 7;
  localparam int F_N = 6;
  localparam int F_H = 5;
  localparam int F_C = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_CPL = 4'd8,
    OP_SCF = 4'd9,
    OP_CCF = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2,
    LG_NOT = 2'd3
  } logic_sel_e;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W   = 8,
  parameter int NIB = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         half_o,
  output logic         carry_o
);
  logic [W:0]   full;
  logic [NIB:0] half;

  // 9-bit and 5-bit wide sums: the top bit is the carry or borrow
  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      half = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]} - {{NIB{1'b0}}, cin_i};
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      half = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
    end
  end

  assign res_o   = full[W-1:0];
  assign carry_o = full[W];
  assign half_o  = half[NIB];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_AND:  res_o[i] = a_i[i] & b_i[i];
        LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        LG_OR:   res_o[i] = a_i[i] | b_i[i];
        default: res_o[i] = ~a_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic         wb_o,
  output logic [7:0]   flags_o
);
  localparam int NIB = W / 2;

  logic         sub, cin, ar_h, ar_c;
  logic [W-1:0] ar_res, lg_res;
  logic_sel_e   lg_sel;

  assign sub = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP);
  assign cin = ((op_i == OP_ADC) || (op_i == OP_SBC)) & flags_i[F_C];

  always_comb begin
    unique case (op_i)
      OP_AND:  lg_sel = LG_AND;
      OP_XOR:  lg_sel = LG_XOR;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_NOT;
    endcase
  end

  alu_arith #(.W(W), .NIB(NIB)) u_arith (
    .a_i(a_i), .b_i(b_i), .cin_i(cin), .sub_i(sub),
    .res_o(ar_res), .half_o(ar_h), .carry_o(ar_c)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  always_comb begin
    res_o   = a_i;
    wb_o    = 1'b0;
    flags_o = {flags_i[7:4], 4'h0};
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res_o = ar_res;
        wb_o  = 1'b1;
        flags_o[F_Z] = (ar_res == '0);
        flags_o[F_N] = sub;
        flags_o[F_H] = ar_h;
        flags_o[F_C] = ar_c;
      end
      OP_CMP: begin
        flags_o[F_Z] = (ar_res == '0);
        flags_o[F_N] = 1'b1;
        flags_o[F_H] = ar_h;
        flags_o[F_C] = ar_c;
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_o = lg_res;
        wb_o  = 1'b1;
        flags_o[F_Z] = (lg_res == '0);
        flags_o[F_N] = 1'b0;
        flags_o[F_H] = (op_i == OP_AND);
        flags_o[F_C] = 1'b0;
      end
      OP_CPL: begin
        res_o = lg_res;
        wb_o  = 1'b1;
        flags_o[F_N] = 1'b1;
        flags_o[F_H] = 1'b1;
      end
      OP_SCF, OP_CCF: begin
        flags_o[F_N] = 1'b0;
        flags_o[F_H] = 1'b0;
        flags_o[F_C] = (op_i == OP_SCF) ? 1'b1 : ~flags_i[F_C];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [3:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  output logic [7:0] result_o,
  output logic       wb_o,
  output logic [7:0] next_flags_o,
  output logic [7:0] flags_o
);
  alu_op_e    op;
  logic [7:0] flags_q;

  assign op = alu_op_e'(op_i);

  alu_core #(.W(DATA_W)) u_core (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .flags_i(flags_q),
    .res_o(result_o), .wb_o(wb_o), .flags_o(next_flags_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= 8'h00;
    else if (valid_i) flags_q <= next_flags_o;
  end

  assign flags_o = flags_q;

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[3:0] == 4'h0); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o)); // R11
  AST_LOAD_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o == $past(next_flags_o)); // R11
  AST_SUB_SETS_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd2 || op_i == 4'd3)) |=> flags_o[F_N]); // R4
  AST_CMP_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd7) |-> (!wb_o && result_o == acc_i)); // R8
  AST_AND_SETS_H: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd4) |=> (flags_o[F_H] && !flags_o[F_C])); // R6
  AST_SCF_SETS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd9) |=> flags_o[F_C]); // R10
  AST_BAD_OP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd10) |-> (!wb_o && next_flags_o == flags_o)); // R12
endmodule

// File: tb/tb_alu_flag_unit.sv
`timescale 1ns/1ps
module tb_alu_flag_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [7:0] result_o, next_flags_o, flags_o;
  logic       wb_o;

  int n_vec = 0, n_bad = 0;
  logic [7:0] mflags = 8'h00;

  always #2.5 clk_i = ~clk_i;

  alu_flag_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o), .wb_o(wb_o),
    .next_flags_o(next_flags_o), .flags_o(flags_o)
  );

  // returns {wb, result, flags}
  function automatic logic [16:0] model(int op, int a, int b, logic [7:0] f);
    int cin, s, r, z, n, h, c, wb;
    cin = ((op == 1) || (op == 3)) ? int'(f[4]) : 0;
    z = int'(f[7]); n = int'(f[6]); h = int'(f[5]); c = int'(f[4]);
    r = a; wb = 0;
    case (op)
      0, 1: begin
        s = a + b + cin; r = s % 256; wb = 1;
        z = (r == 0); n = 0; h = ((a % 16) + (b % 16) + cin > 15); c = (s > 255);
      end
      2, 3, 7: begin
        s = a - b - cin; r = (s + 512) % 256;
        z = (r == 0); n = 1; h = ((a % 16) < (b % 16) + cin); c = (a < b + cin);
        if (op == 7) r = a; else wb = 1;
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b); wb = 1;
        z = (r == 0); n = 0; h = (op == 4); c = 0;
      end
      8: begin r = 255 - a; wb = 1; n = 1; h = 1; end
      9:  begin n = 0; h = 0; c = 1; end
      10: begin n = 0; h = 0; c = 1 - c; end
      default: ;
    endcase
    return {wb[0], r[7:0], z[0], n[0], h[0], c[0], 4'h0};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
      4: return "R6";  5, 6: return "R7"; 7: return "R8"; 8: return "R9";
      9, 10: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(int op, int a, int b, bit v);
    logic [16:0] exp;
    @(negedge clk_i);
    op_i = op[3:0]; acc_i = a[7:0]; opnd_i = b[7:0]; valid_i = v;
    #1;
    exp = model(op, a, b, mflags);
    n_vec++;
    if ({wb_o, result_o, next_flags_o} !== exp) begin
      n_bad++;
      $display("FAIL %s/R13 op=%0d a=%02h b=%02h: got wb=%b res=%02h nf=%02h exp wb=%b res=%02h nf=%02h",
               tag_of(op), op, a, b, wb_o, result_o, next_flags_o, exp[16], exp[15:8], exp[7:0]);
    end
    @(posedge clk_i); #1;
    if (v) mflags = exp[7:0];
    n_vec++;
    if (flags_o !== mflags) begin
      n_bad++;
      $display("FAIL R11/R1 op=%0d valid=%b: got flags=%02h exp %02h", op, v, flags_o, mflags);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #12; rst_ni = 1'b1;
    @(negedge clk_i);
    n_vec++;
    if (flags_o !== 8'h00) begin // R1 reset value
      n_bad++;
      $display("FAIL R1 reset: got %02h exp 00", flags_o);
    end
    // directed corners
    apply(0, 8'h0F, 8'h01, 1);  // R2 half carry
    apply(0, 8'hFF, 8'h01, 1);  // R2 zero, H, C
    apply(9, 8'h00, 8'h00, 1);  // R10 set carry
    apply(1, 8'hFF, 8'h00, 1);  // R3 carry-in ripples
    apply(9, 8'h00, 8'h00, 1);
    apply(3, 8'h00, 8'hFF, 1);  // R5 B+Cin = 256
    apply(3, 8'h10, 8'h0F, 1);  // R5 half borrow with cin
    apply(2, 8'h10, 8'h01, 1);  // R4
    apply(7, 8'h42, 8'h42, 1);  // R8 equal
    apply(4, 8'hF0, 8'h0F, 1);  // R6 zero
    apply(5, 8'hAA, 8'hAA, 1);  // R7
    apply(6, 8'h00, 8'h00, 1);  // R7
    apply(8, 8'h5A, 8'h00, 1);  // R9
    apply(10, 8'h00, 8'h00, 1); // R10 complement carry
    apply(10, 8'h00, 8'h00, 0); // R11 no load
    apply(13, 8'h33, 8'h44, 1); // R12 unused code
    apply(15, 8'hFF, 8'hFF, 1); // R12
    // seeded random sequences
    for (int i = 0; i < 4000; i++) begin
      int op, a, b;
      bit v;
      op = int'($urandom % 16);
      a  = int'($urandom % 256);
      b  = int'($urandom % 256);
      v  = (($urandom % 4) != 0);
      apply(op, a, b, v);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule